// File: doc/BRIEF.md
# Interrupt Request Flag Register

This block is an 8-bit bus register that captures single-cycle event pulses from six peripheral sources into sticky interrupt request flags. Software reads the register to see which events are pending. It clears a pending flag by writing a 0 to that flag's bit. Writing a 1 to a flag bit does nothing, so a read-modify-write cannot set a flag by mistake.

The flag for the 16-bit timer overflow is read-only. Software clears it through a companion clear bit at the bottom of the register. That bit always reads back as 1, so a plain read-modify-write never clears the overflow flag by accident. Each flag is ANDed with its own enable input, and the results are ORred into one registered interrupt line. Bit positions matter to software and are fixed:

| Bit | Content |
|-----|---------|
| 7 | direct-transfer flag |
| 6 | A/D-complete flag |
| 5 | unused, reads 0 |
| 4 | capture-edge flag |
| 3 | high/16-bit compare flag |
| 2 | low compare flag |
| 1 | timer overflow flag |
| 0 | overflow clear bit |

Top module: `irq_flag_reg`

## Requirements
- R1: After reset `rdata_o` reads 8'h01 when the register is addressed, and `irq_o` is 0.
- R2: Each event pulse sets its flag at the next clock edge, and the flag then holds until it is cleared. The mapping is `evt_dxfer_i`→bit 7, `evt_adc_i`→bit 6, `evt_capture_i`→bit 4, `evt_cmp_hi_i`→bit 3, `evt_cmp_lo_i`→bit 2, `evt_tmr_ovf_i`→bit 1.
- R3: An addressed write with a 0 in bit 7, 6, 4, 3 or 2 clears that flag. A 1 in any of these bits leaves the flag unchanged.
- R4: The value written to bit 1 never changes the timer overflow flag.
- R5: An addressed write with bit 0 equal to 0 clears the timer overflow flag. Bit 0 reads 1 at all times.
- R6: Bit 5 always reads 0, and writes to it have no effect.
- R7: When an event pulse and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R8: `irq_o` is a register. Its value in a cycle is 1 exactly when, in the previous cycle, some flag was set and its enable was 1. The enable order in `irq_en_i` is [0] overflow, [1] low compare, [2] high compare, [3] capture, [4] A/D, [5] direct transfer.
- R9: A write whose `addr_i` differs from `REG_ADDR` changes nothing. While `addr_i` differs from `REG_ADDR`, `rdata_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | AW (8) | Bus address |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational from address |
| evt_dxfer_i | input | 1 | Direct-transfer event pulse |
| evt_adc_i | input | 1 | A/D conversion complete pulse |
| evt_capture_i | input | 1 | Capture edge detected pulse |
| evt_cmp_hi_i | input | 1 | High-half or 16-bit compare match pulse |
| evt_cmp_lo_i | input | 1 | Low-half compare match pulse |
| evt_tmr_ovf_i | input | 1 | 16-bit timer wrap pulse |
| irq_en_i | input | 6 | Per-flag interrupt enables |
| irq_o | output | 1 | Registered combined interrupt |

## Verification
Some rules are checked by assertions on every cycle:

- each flag cell obeys set-wins, clear and hold;
- bit 0 reads 1 and bit 5 reads 0 whenever the register is addressed;
- an all-ones write with no events leaves the flags unchanged;
- `irq_o` follows the enabled flags one cycle later.

The bench scenarios are needed for the rest. They show that each event lands on its own bit position. They show that a write of 0 to bit 1 does not clear the overflow flag while a 0 in bit 0 does. They also show that writes to other addresses are ignored and that enable masking works across mixed sequences.

// File: rtl/irqf_pkg.sv
package irqf_pkg;
  localparam int unsigned NFLAG   = 6;
  localparam int unsigned REG_W   = 8;
  localparam int unsigned CLR_BIT = 0;
  localparam int unsigned RSV_BIT = 5;
  localparam int unsigned OVF_IDX = 0;

  // flag index -> register bit position
  function automatic int unsigned flag_pos(input int unsigned idx);
    case (idx)
      0:       return 1;
      1:       return 2;
      2:       return 3;
      3:       return 4;
      4:       return 6;
      default: return 7;
    endcase
  endfunction
endpackage

// File: rtl/irqf_cell.sv
module irqf_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  logic q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q_q <= 1'b0;
    else if (set_i)   q_q <= 1'b1;  // event beats clear
    else if (clr_i)   q_q <= 1'b0;
  end

  assign q_o = q_q;

  // R7
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> q_o);
  // R3
  clr_takes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !q_o);
  // R2
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!set_i && !clr_i) |=> $stable(q_o));
endmodule

// File: rtl/irqf_out.sv
module irqf_out
  import irqf_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sel_i,
  input  logic [NFLAG-1:0] flags_i,
  input  logic [NFLAG-1:0] en_i,
  output logic [REG_W-1:0] rdata_o,
  output logic             irq_o
);
  logic [REG_W-1:0] view;
  logic             irq_q;

  always_comb begin
    view = '0;
    for (int unsigned i = 0; i < NFLAG; i++) view[flag_pos(i)] = flags_i[i];
    view[CLR_BIT] = 1'b1;
  end

  assign rdata_o = sel_i ? view : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |(flags_i & en_i);
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/irq_flag_reg.sv
module irq_flag_reg
  import irqf_pkg::*;
#(
  parameter int unsigned AW       = 8,
  parameter logic [AW-1:0] REG_ADDR = 8'hF7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [AW-1:0]    addr_i,
  input  logic             we_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o,
  input  logic             evt_dxfer_i,
  input  logic             evt_adc_i,
  input  logic             evt_capture_i,
  input  logic             evt_cmp_hi_i,
  input  logic             evt_cmp_lo_i,
  input  logic             evt_tmr_ovf_i,
  input  logic [NFLAG-1:0] irq_en_i,
  output logic             irq_o
);
  logic             sel, wr;
  logic [NFLAG-1:0] evt, clr, flag_q;
  logic             unused_wbits;

  assign sel = (addr_i == REG_ADDR);
  assign wr  = we_i & sel;
  assign evt = {evt_dxfer_i, evt_adc_i, evt_capture_i,
                evt_cmp_hi_i, evt_cmp_lo_i, evt_tmr_ovf_i};
  assign unused_wbits = ^{wdata_i[RSV_BIT], wdata_i[flag_pos(OVF_IDX)]};

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    // overflow flag is cleared only via the companion bit
    localparam int unsigned CBIT = (g == OVF_IDX) ? CLR_BIT : flag_pos(g);
    assign clr[g] = wr & ~wdata_i[CBIT];
    irqf_cell u_cell (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .set_i (evt[g]),
      .clr_i (clr[g]),
      .q_o   (flag_q[g])
    );
  end

  irqf_out u_out (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sel_i  (sel),
    .flags_i(flag_q),
    .en_i   (irq_en_i),
    .rdata_o(rdata_o),
    .irq_o  (irq_o)
  );

  // R5
  clr_bit_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel |-> rdata_o[CLR_BIT]);
  // R6
  rsv_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rdata_o[RSV_BIT]);
  // R3
  ones_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && (&wdata_i) && !(|evt)) |=> $stable(flag_q));
  // R8
  irq_on_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(flag_q & irq_en_i)) |=> irq_o);
  // R8
  irq_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|(flag_q & irq_en_i)) |=> !irq_o);
  // R9
  foreign_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sel && !(|evt)) |=> $stable(flag_q));
endmodule

// File: tb/irq_flag_reg_bench.sv
`timescale 1ns/1ps
module irq_flag_reg_bench;
  localparam logic [7:0] ADDR = 8'hF7;

  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic [7:0] addr_i = ADDR, wdata_i = 8'hFF, rdata_o;
  logic       we_i = 1'b0, irq_o;
  logic [5:0] evt = '0, irq_en_i = '0;

  int total = 0, bad = 0;
  bit m_flag [6];
  bit m_irq;
  int pos [6] = '{1, 2, 3, 4, 6, 7};

  always #4 clk_i = ~clk_i;

  irq_flag_reg u_irq_flag_reg (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .we_i(we_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o),
    .evt_dxfer_i(evt[5]), .evt_adc_i(evt[4]), .evt_capture_i(evt[3]),
    .evt_cmp_hi_i(evt[2]), .evt_cmp_lo_i(evt[1]), .evt_tmr_ovf_i(evt[0]),
    .irq_en_i(irq_en_i), .irq_o(irq_o)
  );

  function automatic logic [7:0] model_read();
    logic [7:0] v = 8'h01;
    if (addr_i != ADDR) return 8'h00;
    for (int i = 0; i < 6; i++) v[pos[i]] = m_flag[i];
    return v;
  endfunction

  task automatic check(input string req);
    total++;
    if (rdata_o !== model_read() || irq_o !== m_irq) begin
      bad++;
      $display("FAIL %s: rdata=%h irq=%b expected rdata=%h irq=%b",
               req, rdata_o, irq_o, model_read(), m_irq);
    end
  endtask

  // apply inputs, advance one clock in model and DUT, compare at negedge
  task automatic cyc(input string req, input logic [5:0] e, input logic w,
                     input logic [7:0] d, input logic [7:0] a);
    bit nirq;
    evt = e; we_i = w; wdata_i = d; addr_i = a;
    @(posedge clk_i);
    nirq = 0;
    for (int i = 0; i < 6; i++) if (m_flag[i] && irq_en_i[i]) nirq = 1;
    m_irq = nirq;
    for (int i = 0; i < 6; i++) begin
      bit c = w && (a == ADDR) && !d[(i == 0) ? 0 : pos[i]];
      if (e[i]) m_flag[i] = 1;
      else if (c) m_flag[i] = 0;
    end
    @(negedge clk_i);
    check(req);
    evt = '0; we_i = 0;
  endtask

  initial begin
    #(200000 * 8);
    bad++; total++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 6; i++) m_flag[i] = 0;
    m_irq = 0;
    repeat (2) @(negedge clk_i);
    check("R1");
    rst_ni = 1;
    @(negedge clk_i);
    check("R1");
    // R2: each event alone
    for (int i = 0; i < 6; i++) cyc("R2", 6'(1 << i), 0, 8'hFF, ADDR);
    cyc("R2", '0, 0, 8'hFF, ADDR);
    // R3 R4 R5: all-ones write keeps everything
    cyc("R3", '0, 1, 8'hFF, ADDR);
    cyc("R3", '0, 1, 8'h7F, ADDR);   // clear direct-transfer
    cyc("R3", '0, 1, 8'hBF, ADDR);   // clear A/D
    cyc("R4", '0, 1, 8'hFD, ADDR);   // bit1 = 0 must not clear
    cyc("R5", '0, 1, 8'hFE, ADDR);   // companion bit clears overflow
    cyc("R5", '0, 0, 8'h00, ADDR);
    // R6
    cyc("R6", '0, 1, 8'h20, ADDR);
    cyc("R6", '0, 1, 8'hFF, ADDR);
    // R7: set and clear together
    cyc("R7", 6'h3F, 1, 8'h00, ADDR);
    cyc("R7", '0, 0, 8'h00, ADDR);
    // R9: foreign address write and read
    cyc("R9", '0, 1, 8'h00, 8'h10);
    cyc("R9", '0, 0, 8'h00, ADDR);
    // R8: enable masking
    irq_en_i = 6'h01;
    cyc("R8", '0, 0, 8'h00, ADDR);
    cyc("R8", '0, 1, 8'hFE, ADDR);
    cyc("R8", '0, 0, 8'h00, ADDR);
    irq_en_i = 6'h20;
    cyc("R8", '0, 0, 8'h00, ADDR);
    cyc("R8", '0, 1, 8'h7F, ADDR);
    cyc("R8", '0, 0, 8'h00, ADDR);
    // mixed traffic
    for (int n = 0; n < 400; n++) begin
      logic [5:0] e = 6'($urandom) & 6'($urandom);
      logic [7:0] d = 8'($urandom) | 8'($urandom);
      logic [7:0] a = ($urandom % 4 == 0) ? 8'h33 : ADDR;
      irq_en_i = 6'($urandom);
      cyc("R2", e, 1'($urandom), d, a);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule